// File: doc/BRIEF.md
# Two-Operand Elastic Adder with Side-Bit Passthrough

This block adds two unsigned operands that arrive on separate valid/ready channels. Each channel's payload holds the operand plus a group of side bits. The side bits play no part in the sum. The block joins the two handshakes, so a transfer happens only when both inputs and the consumer agree. It adds the two operand fields. It returns the sum together with the side bits of both inputs, in a fixed layout, so that each output bit can be traced back to the input bit it came from.

Where the operand sits inside each payload is set at compile time by an offset and a width. A field other than the usual low-order value, such as a tag in the middle of the payload, can therefore be chosen as the operand. The remaining payload bits then become the side bits for that channel.

The datapath is purely combinational and holds no state. Buffering belongs to the channels around the block.

Top module: `meta_carry_adder`

## Requirements
- R1: `y_valid` is high exactly when `a_valid` and `b_valid` are both high.
- R2: `a_ready` equals `y_ready` AND `b_valid`. `b_ready` equals `y_ready` AND `a_valid`. A transfer on one input therefore never happens without a transfer on the other.
- R3: The operand of each input is the unsigned field `payload[OFF+W-1:OFF]` of that input. `y_sum` equals (operand A + operand B) modulo 2^RES_W.
- R4: With the default RES_W (one bit wider than the wider operand), the carry is never lost. For example, 63 + 511 gives 574 in the default build.
- R5: `y_extra` holds the side bits of input A in bits [A_X-1:0] and the side bits of input B in bits [A_X+B_X-1:A_X].
- R6: Within one input, the side bits list the payload bits below the operand first, in bit order, at the low end. The payload bits above the operand follow.
- R7: The outputs follow the inputs within the same cycle, with no clock edge in between. The block stores no payload.
- R8: Changing only side bits leaves `y_sum` unchanged. Changing only operand bits leaves `y_extra` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_valid | input | 1 | Input A carries a payload |
| a_ready | output | 1 | Input A payload is taken this cycle when valid |
| a_payload | input | A_W+A_X | Operand A field plus its side bits |
| b_valid | input | 1 | Input B carries a payload |
| b_ready | output | 1 | Input B payload is taken this cycle when valid |
| b_payload | input | B_W+B_X | Operand B field plus its side bits |
| y_valid | output | 1 | Joined result available |
| y_ready | input | 1 | Consumer accepts the result |
| y_sum | output | RES_W | Sum of the two operand fields |
| y_extra | output | A_X+B_X | Side bits of A (low) and of B (high) |

## Verification
The bench builds the block twice.

The default build uses 6- and 9-bit operands at offset zero, 17 and 3 side bits, and a 10-bit result. It reaches the full-carry case, the eight handshake combinations and the isolation of side bits from the sum.

The second build places a 4-bit operand at offset 3 of a 12-bit payload and a 5-bit operand at the top of an 11-bit payload. Its result is narrowed to 5 bits. This build reaches the split and high-end layouts of the side bits and the modulo wrap of the sum.

// File: rtl/mca_pkg.sv
package mca_pkg;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mca_field_split.sv
// Separates one payload into its operand field and the remaining side bits.
module mca_field_split #(
  parameter int unsigned PW  = 23,
  parameter int unsigned OFF = 0,
  parameter int unsigned W   = 6
) (
  input  logic [PW-1:0]   payload,
  output logic [W-1:0]    operand,
  output logic [PW-W-1:0] extra
);

  assign operand = payload[OFF +: W];

  // Bits below the operand go low, bits above follow.
  generate
    if (OFF == 0) begin : g_at_bottom
      assign extra = payload[PW-1:W];
    end else if (OFF + W == PW) begin : g_at_top
      assign extra = payload[OFF-1:0];
    end else begin : g_in_middle
      assign extra = {payload[PW-1:OFF+W], payload[OFF-1:0]};
    end
  endgenerate

  always_comb begin
    AST_SPLIT_CONSERVE: assert ($countones(operand) + $countones(extra) == $countones(payload)); // R6
  end

endmodule

// File: rtl/mca_join.sv
// Join of two input handshakes into one output handshake.
module mca_join (
  input  logic a_valid,
  input  logic b_valid,
  input  logic y_ready,
  output logic a_ready,
  output logic b_ready,
  output logic y_valid
);

  assign y_valid = a_valid & b_valid;
  assign a_ready = y_ready & b_valid;
  assign b_ready = y_ready & a_valid;

  always_comb begin
    AST_PAIRED_TAKE: assert ((a_valid && a_ready) == (b_valid && b_ready)); // R2
  end

endmodule

// File: rtl/mca_sum.sv
// Unsigned adder with a configurable result width.
module mca_sum
  import mca_pkg::*;
#(
  parameter int unsigned A_W   = 6,
  parameter int unsigned B_W   = 9,
  parameter int unsigned RES_W = 10
) (
  input  logic [A_W-1:0]   op_a,
  input  logic [B_W-1:0]   op_b,
  output logic [RES_W-1:0] sum
);

  localparam int unsigned NAT_W = imax(A_W, B_W) + 1;
  localparam int unsigned INT_W = imax(NAT_W, RES_W);

  logic [INT_W-1:0] full;

  assign full = INT_W'(op_a) + INT_W'(op_b);
  assign sum  = full[RES_W-1:0];

  always_comb begin
    AST_LSB_PARITY: assert (sum[0] == (op_a[0] ^ op_b[0])); // R3
  end

  generate
    if (RES_W >= NAT_W) begin : g_wide
      always_comb begin
        AST_NO_OVERFLOW: assert (INT_W'(sum) >= INT_W'(op_a) && INT_W'(sum) >= INT_W'(op_b)); // R4
      end
    end
  endgenerate

endmodule

// File: rtl/meta_carry_adder.sv
module meta_carry_adder
  import mca_pkg::*;
#(
  parameter int unsigned A_W   = 6,
  parameter int unsigned A_X   = 17,
  parameter int unsigned A_OFF = 0,
  parameter int unsigned B_W   = 9,
  parameter int unsigned B_X   = 3,
  parameter int unsigned B_OFF = 0,
  parameter int unsigned RES_W = imax(A_W, B_W) + 1
) (
  input  logic                 a_valid,
  output logic                 a_ready,
  input  logic [A_W+A_X-1:0]   a_payload,
  input  logic                 b_valid,
  output logic                 b_ready,
  input  logic [B_W+B_X-1:0]   b_payload,
  output logic                 y_valid,
  input  logic                 y_ready,
  output logic [RES_W-1:0]     y_sum,
  output logic [A_X+B_X-1:0]   y_extra
);

  localparam int unsigned A_PW = A_W + A_X;
  localparam int unsigned B_PW = B_W + B_X;

  logic [A_W-1:0] op_a;
  logic [B_W-1:0] op_b;
  logic [A_X-1:0] side_a;
  logic [B_X-1:0] side_b;

  mca_field_split #(.PW(A_PW), .OFF(A_OFF), .W(A_W)) u_split_a (
    .payload (a_payload),
    .operand (op_a),
    .extra   (side_a)
  );

  mca_field_split #(.PW(B_PW), .OFF(B_OFF), .W(B_W)) u_split_b (
    .payload (b_payload),
    .operand (op_b),
    .extra   (side_b)
  );

  mca_join u_join (
    .a_valid (a_valid),
    .b_valid (b_valid),
    .y_ready (y_ready),
    .a_ready (a_ready),
    .b_ready (b_ready),
    .y_valid (y_valid)
  );

  mca_sum #(.A_W(A_W), .B_W(B_W), .RES_W(RES_W)) u_sum (
    .op_a (op_a),
    .op_b (op_b),
    .sum  (y_sum)
  );

  assign y_extra = {side_b, side_a};

  always_comb begin
    AST_FIRE_MATCH: assert ((a_valid && a_ready) == (y_valid && y_ready)); // R1
    AST_SIDE_COUNT: assert ($countones(y_extra) ==
                            $countones(a_payload) - $countones(op_a) +
                            $countones(b_payload) - $countones(op_b)); // R5
  end

endmodule

// File: tb/meta_carry_adder_tb_top.sv
module meta_carry_adder_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // default build
  logic        a_v, a_r, b_v, b_r, y_v, y_r;
  logic [22:0] a_p;
  logic [11:0] b_p;
  logic [9:0]  y_s;
  logic [19:0] y_x;

  meta_carry_adder dut_i (
    .a_valid(a_v), .a_ready(a_r), .a_payload(a_p),
    .b_valid(b_v), .b_ready(b_r), .b_payload(b_p),
    .y_valid(y_v), .y_ready(y_r), .y_sum(y_s), .y_extra(y_x)
  );

  // tag-operand build: A op [6:3] of 12, B op [10:6] of 11, 5-bit result
  logic        ta_v, ta_r, tb_v, tb_r, ty_v, ty_r;
  logic [11:0] ta_p;
  logic [10:0] tb_p;
  logic [4:0]  ty_s;
  logic [13:0] ty_x;

  meta_carry_adder #(
    .A_W(4), .A_X(8), .A_OFF(3),
    .B_W(5), .B_X(6), .B_OFF(6), .RES_W(5)
  ) dut_tag_i (
    .a_valid(ta_v), .a_ready(ta_r), .a_payload(ta_p),
    .b_valid(tb_v), .b_ready(tb_r), .b_payload(tb_p),
    .y_valid(ty_v), .y_ready(ty_r), .y_sum(ty_s), .y_extra(ty_x)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // drive on the falling edge, let the combinational paths settle
  task automatic drive(input logic av, input logic bv, input logic yr,
                       input logic [5:0] aop, input logic [16:0] ax,
                       input logic [8:0] bop, input logic [2:0] bx);
    @(negedge clk);
    a_v = av; b_v = bv; y_r = yr;
    a_p = {ax, aop};
    b_p = {bx, bop};
    #1;
  endtask

  task automatic check_data(input string tag, input logic [5:0] aop, input logic [16:0] ax,
                            input logic [8:0] bop, input logic [2:0] bx);
    chk({tag, " R3 R4 sum"}, 64'(y_s), 64'(aop) + 64'(bop));
    chk({tag, " R5 side"}, 64'(y_x), 64'({bx, ax}));
  endtask

  task automatic t_idle();
    chk("R1 idle y_valid", 64'(y_v), 64'd0);
    chk("R2 idle a_ready", 64'(a_r), 64'd0);
    chk("R2 idle b_ready", 64'(b_r), 64'd0);
  endtask

  task automatic t_handshake();
    for (int k = 0; k < 8; k++) begin
      logic av, bv, yr;
      av = k[0]; bv = k[1]; yr = k[2];
      drive(av, bv, yr, 6'd5, 17'h1, 9'd7, 3'h2);
      chk("R1 y_valid", 64'(y_v), 64'(av & bv));
      chk("R2 a_ready", 64'(a_r), 64'(yr & bv));
      chk("R2 b_ready", 64'(b_r), 64'(yr & av));
    end
  endtask

  task automatic t_directed();
    drive(1, 1, 1, 6'd0, 17'h00000, 9'd0, 3'h0);   check_data("zero", 6'd0, 17'h0, 9'd0, 3'h0);
    drive(1, 1, 1, 6'd63, 17'h1FFFF, 9'd511, 3'h7); check_data("max", 6'd63, 17'h1FFFF, 9'd511, 3'h7);
    chk("R4 full carry", 64'(y_s), 64'd574);
    drive(1, 1, 0, 6'd37, 17'h0A5A5, 9'd200, 3'h5); check_data("mid", 6'd37, 17'h0A5A5, 9'd200, 3'h5);
    drive(1, 1, 1, 6'd1, 17'h10000, 9'd1, 3'h4);    check_data("one", 6'd1, 17'h10000, 9'd1, 3'h4);
  endtask

  // R7: inputs change between edges, the outputs follow before the next edge
  task automatic t_same_cycle();
    @(negedge clk);
    a_v = 1; b_v = 1; y_r = 1;
    a_p = {17'h00011, 6'd10}; b_p = {3'h1, 9'd20};
    #0.5;
    chk("R7 first value", 64'(y_s), 64'd30);
    a_p = {17'h00022, 6'd12}; b_p = {3'h6, 9'd100};
    #0.5;
    chk("R7 updated sum", 64'(y_s), 64'd112);
    chk("R7 updated side", 64'(y_x), 64'({3'h6, 17'h00022}));
  endtask

  task automatic t_isolation();
    drive(1, 1, 1, 6'd21, 17'h00000, 9'd300, 3'h0);
    drive(1, 1, 1, 6'd21, 17'h1F0F0, 9'd300, 3'h7);
    chk("R8 side change keeps sum", 64'(y_s), 64'd321);
    drive(1, 1, 1, 6'd63, 17'h1F0F0, 9'd0, 3'h7);
    chk("R8 operand change keeps side", 64'(y_x), 64'({3'h7, 17'h1F0F0}));
  endtask

  task automatic t_random();
    for (int i = 0; i < 60; i++) begin
      logic [5:0] aop; logic [16:0] ax; logic [8:0] bop; logic [2:0] bx;
      logic av, bv, yr;
      aop = 6'($urandom); ax = 17'($urandom); bop = 9'($urandom); bx = 3'($urandom);
      av = 1'($urandom); bv = 1'($urandom); yr = 1'($urandom);
      drive(av, bv, yr, aop, ax, bop, bx);
      check_data("rand", aop, ax, bop, bx);
      chk("R2 rand pairing", 64'(a_v & a_r), 64'(b_v & b_r));
    end
  endtask

  task automatic t_tag();
    logic [3:0] aop; logic [4:0] bop;
    logic [4:0] a_hi; logic [2:0] a_lo; logic [5:0] b_lo;
    aop = 4'd15; bop = 5'd31; a_hi = 5'b10110; a_lo = 3'b011; b_lo = 6'b100101;
    @(negedge clk);
    ta_v = 1; tb_v = 1; ty_r = 1;
    ta_p = {a_hi, aop, a_lo};
    tb_p = {bop, b_lo};
    #1;
    chk("R3 tag sum wraps", 64'(ty_s), 64'd14);
    chk("R6 tag side layout", 64'(ty_x), 64'({b_lo, a_hi, a_lo}));
    chk("R1 tag y_valid", 64'(ty_v), 64'd1);
    @(negedge clk);
    ta_p = {5'b01001, 4'd3, 3'b100};
    tb_p = {5'd4, 6'b011010};
    #1;
    chk("R3 tag sum", 64'(ty_s), 64'd7);
    chk("R6 tag side layout 2", 64'(ty_x), 64'({6'b011010, 5'b01001, 3'b100}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    a_v = 0; b_v = 0; y_r = 0; a_p = '0; b_p = '0;
    ta_v = 0; tb_v = 0; ty_r = 0; ta_p = '0; tb_p = '0;
    repeat (3) @(posedge clk);
    #1;
    t_idle();
    rst = 1'b0;
    t_handshake();
    t_directed();
    t_same_cycle();
    t_isolation();
    t_random();
    t_tag();
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule